// File: doc/BRIEF.md
# BCD Calendar and Timekeeping Core

This block keeps the time of day and the calendar date in packed BCD. It is stepped by a one-cycle `tick` enable that arrives once per second, and it runs entirely on one synchronous clock. It stores seconds, minutes, hours, day, month, a four-digit year and a day of week. It works out month lengths and applies the full Gregorian leap-year rule directly to the BCD year.

An external setting controller adjusts the fields one at a time through a load strobe or an increment strobe, with a field code and a value. A manual increment wraps inside its own field and never ripples into the next field. A load is accepted only when the value is legal for that field. If the day no longer fits after the month or year changes, it is pulled back to the last day of the new month.

Top module: `cal_core`

## Requirements
- R1: A synchronous active-high `rst` loads 2000-01-01 00:00:00 (year 16'h2000, month 8'h01, day 8'h01, all time fields 8'h00), with weekday 6 and `leapYear` 1.
- R2: Seconds and minutes are two BCD digits in the range 00..59. A `tick` advances the seconds. A units digit of 9 rolls to 0 and increments the tens digit. Seconds at 59 roll to 00 and advance the minutes in the same cycle.
- R3: Hours run from 00 to 23. A tick that takes 23:59:59 to 00:00:00 advances both the day and the weekday in that same cycle.
- R4: Months 04, 06, 09 and 11 are 30 days long. Every other month except 02 is 31 days long.
- R5: February is 29 days long when `leapYear` is 1 and 28 days long otherwise.
- R6: When a tick carry reaches a day at the month length, the day returns to 01, not 00, and the month advances. Month 12 returns to 01 and advances the year. The month is never 00.
- R7: `leapYear` is 1 when the year is a multiple of 400, or when it is a multiple of 4 but not of 100. For example, 2024 and 2000 give 1, while 2023 and 1900 give 0.
- R8: The year is two cascaded 00..99 BCD stages. The low pair at 99 rolls to 00 and increments the high pair, so 2099 becomes 2100 and 9999 becomes 0000.
- R9: The weekday counts 1..7, where 7 is followed by 1. A load accepts only 01..07 in `setValue[7:0]`.
- R10: `setInc` with a field code steps that field once. The field codes are 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year and 6 weekday. The step wraps inside the field (59→00, 23→00, month length→01, 12→01, 9999→0000, 7→1) and carries into no other field. Any manual strobe makes the tick in that cycle have no effect.
- R11: `setLoad` writes `setValue` into the selected field. Time, day and month fields use bits 7:0, and the year uses all 16 bits. The write happens only if the value is valid BCD inside the field's range, and for the day, inside the current month's length. Otherwise the load is ignored. Load wins over a simultaneous `setInc`. Field code 7 changes nothing.
- R12: If a month or year change leaves the day above the new month length, the day becomes that length on the following clock edge.
- R13: With no tick and no manual strobe, every field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle once-per-second advance enable |
| setLoad | input | 1 | Load `setValue` into the selected field |
| setInc | input | 1 | Step the selected field once, without carry |
| setField | input | 3 | Field code: 0 sec, 1 min, 2 hour, 3 day, 4 month, 5 year, 6 weekday |
| setValue | input | 16 | BCD value for a load |
| secBcd | output | 8 | Seconds, BCD |
| minBcd | output | 8 | Minutes, BCD |
| hourBcd | output | 8 | Hours, BCD |
| dayBcd | output | 8 | Day of month, BCD |
| monthBcd | output | 8 | Month, BCD |
| yearBcd | output | 16 | Four-digit year, BCD |
| weekday | output | 4 | Day of week, 1..7 |
| leapYear | output | 1 | 1 when the current year is a leap year |

## Verification
Every field is a register that feeds an output directly, so a wrong carry or wrap appears on the ports on the clock edge right after the tick that caused it. The month-length and leap decisions show only at the edges of a month. Those points are reached by loading dates just before rollovers (end of February in leap and common years, century years, 9999) and then ticking once. A bad clamp or a bad load check shows within one or two cycles of the offending load, as a day above the month length or a field that changed when it should have held.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NF    = 7;            // number of settable fields
  localparam int FW    = 3;            // field code width
  localparam int NTIME = 3;            // sec, min, hour

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;
  localparam int F_WDAY = 6;

  typedef struct packed {
    logic [NF-1:0] bump;  // step with in-field wrap
    logic [NF-1:0] load;  // load request (legality checked in datapath)
  } calStrobe_t;

  function automatic logic bcdOk8(input logic [7:0] v);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
  endfunction

  function automatic logic [7:0] bcdStep(input logic [7:0] v,
                                         input logic [7:0] lo,
                                         input logic [7:0] hi);
    logic [3:0] tensUp;
    tensUp = v[7:4] + 4'd1;
    if (v >= hi)             return lo;
    else if (v[3:0] >= 4'd9) return {tensUp, 4'd0};
    else                     return v + 8'd1;
  endfunction

  // two-digit BCD value divisible by 4
  function automatic logic bcdDiv4(input logic [7:0] v);
    if (v[4]) return (v[3:0] == 4'd2) || (v[3:0] == 4'd6);
    else      return (v[3:0] == 4'd0) || (v[3:0] == 4'd4) || (v[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] monLen(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_leap.sv
module cal_leap (
  input  logic [15:0] yearBcd,
  output logic        leapYear
);
  import cal_pkg::*;
  logic lowZero;
  assign lowZero  = (yearBcd[7:0] == 8'h00);
  // century years look at the upper pair (400 rule), others at the lower pair
  assign leapYear = lowZero ? bcdDiv4(yearBcd[15:8]) : bcdDiv4(yearBcd[7:0]);
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
(
  input  logic                 tick,
  input  logic                 setLoad,
  input  logic                 setInc,
  input  logic [FW-1:0]        setField,
  input  logic [NTIME-1:0]     timeWrap,
  input  logic                 dayWrap,
  input  logic                 monWrap,
  output calStrobe_t           strobe
);
  logic          manual;
  logic [NF-1:0] sel;
  logic [NF-1:0] chain;

  assign manual = setLoad | setInc;

  always_comb begin
    sel = '0;
    if (int'(setField) < NF) sel[setField] = 1'b1;
  end

  always_comb begin
    chain          = '0;
    chain[F_SEC]   = 1'b1;
    chain[F_MIN]   = timeWrap[F_SEC];
    chain[F_HOUR]  = chain[F_MIN]  & timeWrap[F_MIN];
    chain[F_DAY]   = chain[F_HOUR] & timeWrap[F_HOUR];
    chain[F_WDAY]  = chain[F_DAY];
    chain[F_MON]   = chain[F_DAY]  & dayWrap;
    chain[F_YEAR]  = chain[F_MON]  & monWrap;
  end

  always_comb begin
    strobe.load = setLoad ? sel : '0;
    if (manual)    strobe.bump = setLoad ? '0 : sel;
    else if (tick) strobe.bump = chain;
    else           strobe.bump = '0;
  end
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter logic [15:0] RST_YEAR = 16'h2000,
  parameter logic [3:0]  RST_WDAY = 4'd6
) (
  input  logic             clk,
  input  logic             rst,
  input  calStrobe_t       strobe,
  input  logic [15:0]      setValue,
  input  logic             leapYear,
  output logic [7:0]       secBcd,
  output logic [7:0]       minBcd,
  output logic [7:0]       hourBcd,
  output logic [7:0]       dayBcd,
  output logic [7:0]       monthBcd,
  output logic [15:0]      yearBcd,
  output logic [3:0]       weekday,
  output logic [NTIME-1:0] timeWrap,
  output logic             dayWrap,
  output logic             monWrap
);
  logic [7:0]  tReg [NTIME];
  logic [7:0]  dayR, monR;
  logic [15:0] yearR;
  logic [3:0]  wdayR;
  logic [7:0]  mLen;
  logic [7:0]  v8;

  assign v8   = setValue[7:0];
  assign mLen = monLen(monR, leapYear);

  for (genvar g = 0; g < NTIME; g++) begin : g_time
    localparam logic [7:0] HI = (g == F_HOUR) ? 8'h23 : 8'h59;
    always_ff @(posedge clk) begin
      if (rst)                                        tReg[g] <= 8'h00;
      else if (strobe.load[g] && bcdOk8(v8) && v8 <= HI) tReg[g] <= v8;
      else if (strobe.bump[g])                        tReg[g] <= bcdStep(tReg[g], 8'h00, HI);
    end
    assign timeWrap[g] = (tReg[g] >= HI);
  end

  always_ff @(posedge clk) begin
    if (rst) dayR <= 8'h01;
    else if (strobe.load[F_DAY] && bcdOk8(v8) && v8 >= 8'h01 && v8 <= mLen)
      dayR <= v8;
    else if (strobe.bump[F_DAY]) dayR <= bcdStep(dayR, 8'h01, mLen);
    else if (dayR > mLen)        dayR <= mLen;
  end

  always_ff @(posedge clk) begin
    if (rst) monR <= 8'h01;
    else if (strobe.load[F_MON] && bcdOk8(v8) && v8 >= 8'h01 && v8 <= 8'h12)
      monR <= v8;
    else if (strobe.bump[F_MON]) monR <= bcdStep(monR, 8'h01, 8'h12);
  end

  always_ff @(posedge clk) begin
    if (rst) yearR <= RST_YEAR;
    else if (strobe.load[F_YEAR] && bcdOk8(setValue[15:8]) && bcdOk8(setValue[7:0]))
      yearR <= setValue;
    else if (strobe.bump[F_YEAR]) begin
      yearR[7:0] <= bcdStep(yearR[7:0], 8'h00, 8'h99);
      if (yearR[7:0] >= 8'h99) yearR[15:8] <= bcdStep(yearR[15:8], 8'h00, 8'h99);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wdayR <= RST_WDAY;
    else if (strobe.load[F_WDAY] && v8 >= 8'h01 && v8 <= 8'h07) wdayR <= v8[3:0];
    else if (strobe.bump[F_WDAY]) wdayR <= (wdayR >= 4'd7) ? 4'd1 : wdayR + 4'd1;
  end

  assign dayWrap  = (dayR >= mLen);
  assign monWrap  = (monR >= 8'h12);
  assign secBcd   = tReg[F_SEC];
  assign minBcd   = tReg[F_MIN];
  assign hourBcd  = tReg[F_HOUR];
  assign dayBcd   = dayR;
  assign monthBcd = monR;
  assign yearBcd  = yearR;
  assign weekday  = wdayR;
endmodule

// File: rtl/cal_core.sv
module cal_core
  import cal_pkg::*;
#(
  parameter logic [15:0] RST_YEAR = 16'h2000,
  parameter logic [3:0]  RST_WDAY = 4'd6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        setLoad,
  input  logic        setInc,
  input  logic [2:0]  setField,
  input  logic [15:0] setValue,
  output logic [7:0]  secBcd,
  output logic [7:0]  minBcd,
  output logic [7:0]  hourBcd,
  output logic [7:0]  dayBcd,
  output logic [7:0]  monthBcd,
  output logic [15:0] yearBcd,
  output logic [3:0]  weekday,
  output logic        leapYear
);
  calStrobe_t       strobe;
  logic [NTIME-1:0] timeWrap;
  logic             dayWrap, monWrap;

  cal_ctrl u_ctrl (
    .tick(tick), .setLoad(setLoad), .setInc(setInc), .setField(setField),
    .timeWrap(timeWrap), .dayWrap(dayWrap), .monWrap(monWrap), .strobe(strobe)
  );

  cal_datapath #(.RST_YEAR(RST_YEAR), .RST_WDAY(RST_WDAY)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .setValue(setValue), .leapYear(leapYear),
    .secBcd(secBcd), .minBcd(minBcd), .hourBcd(hourBcd), .dayBcd(dayBcd),
    .monthBcd(monthBcd), .yearBcd(yearBcd), .weekday(weekday),
    .timeWrap(timeWrap), .dayWrap(dayWrap), .monWrap(monWrap)
  );

  cal_leap u_leap (.yearBcd(yearBcd), .leapYear(leapYear));
endmodule

// File: rtl/cal_core_chk.sv
module cal_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        tick,
  input logic        setLoad,
  input logic        setInc,
  input logic [2:0]  setField,
  input logic [7:0]  secBcd,
  input logic [7:0]  minBcd,
  input logic [7:0]  hourBcd,
  input logic [7:0]  dayBcd,
  input logic [7:0]  monthBcd,
  input logic [15:0] yearBcd,
  input logic [3:0]  weekday
);
  logic idle;
  assign idle = !setLoad && !setInc;

  // R2
  sec_range_chk: assert property (@(posedge clk) disable iff (rst)
    secBcd <= 8'h59 && secBcd[3:0] <= 4'd9 && minBcd <= 8'h59 && minBcd[3:0] <= 4'd9);

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && idle && secBcd == 8'h59) |=> (secBcd == 8'h00 && minBcd != $past(minBcd)));

  // R3
  hour_roll_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && idle && secBcd == 8'h59 && minBcd == 8'h59 && hourBcd == 8'h23)
      |=> (hourBcd == 8'h00 && dayBcd != $past(dayBcd) && weekday != $past(weekday)));

  // R6
  month_range_chk: assert property (@(posedge clk) disable iff (rst)
    monthBcd >= 8'h01 && monthBcd <= 8'h12 && dayBcd != 8'h00);

  // R9
  wday_range_chk: assert property (@(posedge clk) disable iff (rst)
    weekday >= 4'd1 && weekday <= 4'd7);

  // R10
  inc_nocarry_chk: assert property (@(posedge clk) disable iff (rst)
    (setInc && !setLoad && setField == 3'd0) |=> $stable(minBcd));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && idle) |=> ($stable(secBcd) && $stable(minBcd) && $stable(hourBcd)
                         && $stable(monthBcd) && $stable(yearBcd) && $stable(weekday)));
endmodule

bind cal_core cal_core_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .setLoad(setLoad), .setInc(setInc),
  .setField(setField), .secBcd(secBcd), .minBcd(minBcd), .hourBcd(hourBcd),
  .dayBcd(dayBcd), .monthBcd(monthBcd), .yearBcd(yearBcd), .weekday(weekday)
);

// File: tb/cal_core_bench.sv
`timescale 1ns/1ps
module cal_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, setLoad = 1'b0, setInc = 1'b0;
  logic [2:0]  setField = 3'd0;
  logic [15:0] setValue = 16'h0;
  logic [7:0]  secBcd, minBcd, hourBcd, dayBcd, monthBcd;
  logic [15:0] yearBcd;
  logic [3:0]  weekday;
  logic        leapYear;
  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cal_core u_cal_core (
    .clk(clk), .rst(rst), .tick(tick), .setLoad(setLoad), .setInc(setInc),
    .setField(setField), .setValue(setValue), .secBcd(secBcd), .minBcd(minBcd),
    .hourBcd(hourBcd), .dayBcd(dayBcd), .monthBcd(monthBcd), .yearBcd(yearBcd),
    .weekday(weekday), .leapYear(leapYear)
  );

  // {start y,mo,d,h,mi,s}{expected after one tick}
  localparam int NV = 14;
  localparam logic [111:0] VEC [NV] = '{
    {16'h2024,8'h02,8'h28,8'h23,8'h59,8'h59, 16'h2024,8'h02,8'h29,8'h00,8'h00,8'h00}, // R5
    {16'h2023,8'h02,8'h28,8'h23,8'h59,8'h59, 16'h2023,8'h03,8'h01,8'h00,8'h00,8'h00}, // R5
    {16'h1900,8'h02,8'h28,8'h23,8'h59,8'h59, 16'h1900,8'h03,8'h01,8'h00,8'h00,8'h00}, // R7
    {16'h2000,8'h02,8'h28,8'h23,8'h59,8'h59, 16'h2000,8'h02,8'h29,8'h00,8'h00,8'h00}, // R7
    {16'h2024,8'h04,8'h30,8'h23,8'h59,8'h59, 16'h2024,8'h05,8'h01,8'h00,8'h00,8'h00}, // R4
    {16'h2024,8'h01,8'h30,8'h23,8'h59,8'h59, 16'h2024,8'h01,8'h31,8'h00,8'h00,8'h00}, // R4
    {16'h2024,8'h12,8'h31,8'h23,8'h59,8'h59, 16'h2025,8'h01,8'h01,8'h00,8'h00,8'h00}, // R6
    {16'h2099,8'h12,8'h31,8'h23,8'h59,8'h59, 16'h2100,8'h01,8'h01,8'h00,8'h00,8'h00}, // R8
    {16'h9999,8'h12,8'h31,8'h23,8'h59,8'h59, 16'h0000,8'h01,8'h01,8'h00,8'h00,8'h00}, // R8
    {16'h2024,8'h06,8'h15,8'h10,8'h09,8'h59, 16'h2024,8'h06,8'h15,8'h10,8'h10,8'h00}, // R2
    {16'h2024,8'h06,8'h15,8'h10,8'h59,8'h59, 16'h2024,8'h06,8'h15,8'h11,8'h00,8'h00}, // R2
    {16'h2024,8'h06,8'h15,8'h10,8'h19,8'h09, 16'h2024,8'h06,8'h15,8'h10,8'h19,8'h10}, // R2
    {16'h2024,8'h11,8'h30,8'h23,8'h59,8'h59, 16'h2024,8'h12,8'h01,8'h00,8'h00,8'h00}, // R4
    {16'h2024,8'h09,8'h30,8'h23,8'h59,8'h59, 16'h2024,8'h10,8'h01,8'h00,8'h00,8'h00}  // R6
  };

  function automatic bit refLeap(input logic [15:0] y);
    int n;
    n = y[15:12]*1000 + y[11:8]*100 + y[7:4]*10 + y[3:0];
    return ((n % 4 == 0) && (n % 100 != 0)) || (n % 400 == 0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input bit ld, input bit inc, input logic [2:0] f,
                    input logic [15:0] v, input bit tk);
    setLoad = ld; setInc = inc; setField = f; setValue = v; tick = tk;
    @(negedge clk);
    setLoad = 0; setInc = 0; tick = 0;
  endtask

  task automatic setDate(input logic [15:0] y, input logic [7:0] mo, input logic [7:0] d,
                         input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
    op(1,0,3'd5,y,0); op(1,0,3'd4,{8'h0,mo},0); op(1,0,3'd3,{8'h0,d},0);
    op(1,0,3'd2,{8'h0,h},0); op(1,0,3'd1,{8'h0,mi},0); op(1,0,3'd0,{8'h0,s},0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      mismatched++; compared++;
      $display("FAIL watchdog R13 actual=%0d expected=<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 year", yearBcd, 16'h2000);  check("R1 month", monthBcd, 8'h01);
    check("R1 day", dayBcd, 8'h01);       check("R1 hour", hourBcd, 8'h00);
    check("R1 min", minBcd, 8'h00);       check("R1 sec", secBcd, 8'h00);
    check("R1 wday", weekday, 4'd6);      check("R1 leap", leapYear, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [55:0] s, e;
      s = VEC[i][111:56]; e = VEC[i][55:0];
      setDate(s[55:40], s[39:32], s[31:24], s[23:16], s[15:8], s[7:0]);
      check("R7 leap", leapYear, refLeap(s[55:40]));
      op(0,0,3'd0,16'h0,1);
      check("R8 table year", yearBcd, e[55:40]);
      check("R6 table month", monthBcd, e[39:32]);
      check("R5 table day", dayBcd, e[31:24]);
      check("R3 table hour", hourBcd, e[23:16]);
      check("R2 table min", minBcd, e[15:8]);
      check("R2 table sec", secBcd, e[7:0]);
    end

    // R3 and R9: day rollover moves the weekday, 7 -> 1
    setDate(16'h2024, 8'h03, 8'h10, 8'h23, 8'h59, 8'h59);
    op(1,0,3'd6,16'h0007,0);
    op(0,0,3'd0,16'h0,1);
    check("R3 day", dayBcd, 8'h11); check("R3 hour", hourBcd, 8'h00);
    check("R9 wday wrap", weekday, 4'd1);
    op(0,1,3'd6,16'h0,0);
    check("R9 wday inc", weekday, 4'd2);
    op(0,1,3'd3,16'h0,0);
    check("R10 day inc no wday", weekday, 4'd2);

    // R10 manual increments wrap without carry
    setDate(16'h2023, 8'h02, 8'h28, 8'h23, 8'h30, 8'h59);
    op(0,1,3'd0,16'h0,0);
    check("R10 sec wrap", secBcd, 8'h00); check("R10 sec no carry", minBcd, 8'h30);
    op(0,1,3'd2,16'h0,0);
    check("R10 hour wrap", hourBcd, 8'h00); check("R10 hour no carry", dayBcd, 8'h28);
    op(0,1,3'd3,16'h0,0);
    check("R10 day wrap", dayBcd, 8'h01); check("R10 day no carry", monthBcd, 8'h02);
    op(1,0,3'd4,16'h0012,0); op(0,1,3'd4,16'h0,0);
    check("R10 month wrap", monthBcd, 8'h01); check("R10 month no carry", yearBcd, 16'h2023);
    op(1,0,3'd5,16'h9999,0); op(0,1,3'd5,16'h0,0);
    check("R10 year wrap", yearBcd, 16'h0000);
    op(1,0,3'd0,16'h0010,0); op(1,0,3'd1,16'h0020,0);
    op(0,1,3'd1,16'h0,1);
    check("R10 tick dropped", secBcd, 8'h10); check("R10 min inc", minBcd, 8'h21);

    // R11 illegal loads are ignored
    op(1,0,3'd0,16'h0060,0); check("R11 sec 60", secBcd, 8'h10);
    op(1,0,3'd0,16'h001A,0); check("R11 sec 1A", secBcd, 8'h10);
    op(1,0,3'd4,16'h0004,0); op(1,0,3'd3,16'h0015,0);
    op(1,0,3'd3,16'h0031,0); check("R11 day 31 april", dayBcd, 8'h15);
    op(1,0,3'd4,16'h0013,0); check("R11 month 13", monthBcd, 8'h04);
    op(1,0,3'd6,16'h0008,0); check("R11 wday 8", weekday, 4'd2);
    op(1,1,3'd1,16'h0045,0); check("R11 load beats inc", minBcd, 8'h45);
    op(1,0,3'd7,16'h0000,0);
    check("R11 code 7 sec", secBcd, 8'h10); check("R11 code 7 min", minBcd, 8'h45);

    // R12 clamp after month change and after leap change
    op(1,0,3'd5,16'h2023,0); op(1,0,3'd4,16'h0001,0); op(1,0,3'd3,16'h0031,0);
    op(1,0,3'd4,16'h0002,0); @(negedge clk);
    check("R12 clamp month", dayBcd, 8'h28);
    op(1,0,3'd5,16'h2024,0); op(1,0,3'd3,16'h0029,0);
    op(1,0,3'd5,16'h2023,0); @(negedge clk);
    check("R12 clamp leap", dayBcd, 8'h28);

    // R13 idle hold
    repeat (5) @(negedge clk);
    check("R13 hold sec", secBcd, 8'h10); check("R13 hold day", dayBcd, 8'h28);
    check("R13 hold year", yearBcd, 16'h2023);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule